// File: doc/BRIEF.md
# Clock Source and Low-Power Controller

This block picks the clock that drives a small microcontroller and manages what happens to that clock while the processor waits for an interrupt. All clocks are modelled as single-cycle enable pulses on one fast reference clock. The reference runs `REF_RATIO` times faster than the half-rate crystal clock. A peripheral enable stream (`periClkEn`) follows the chosen source. A CPU enable stream (`cpuClkEn`) is derived from it through a prescaler. The possible sources are the half-rate crystal clock, a PLL, a slow clock (the half-rate crystal divided by 16) and an externally supplied auxiliary clock.

Software sets every option through one 15-bit control word. A wait request halts the CPU stream. If the low-power-on-wait option is on, the wait request also falls back to the slow or auxiliary clock and shuts down the PLL, and possibly the crystal too. The fallback stays in force after wake-up until software writes the control word again. The auxiliary clock can only become the source while an edge counter confirms that it is toggling. Every change into or out of the slow or auxiliary source, and every restart after a hardware stop, can raise an active-low one-cycle interrupt pulse.

Top module: `clk_lp_ctrl`

## Requirements
- R1: After reset, the PLL is off, the source is the half-rate crystal clock, and `periClkEn` and `cpuClkEn` both pulse once every `REF_RATIO` (16) cycles. `xtalEnable` and `clkIrqN` are high, and `srcAux`, `srcSlow`, `inWait` and `auxPresent` are low.
- R2: Control word layout is: bits [1:0] multiplier code, [4:2] divider field (D−1), [7:5] prescaler field (N−1), [8] PLL select, [9] slow select, [10] auxiliary request, [11] crystal stop, [12] low-power-on-wait, [13] wait-uses-auxiliary, [14] interrupt enable. The multiplier code maps 00 to 10, 01 to 6, 10 to 14 and 11 to 8. With the PLL selected, `periClkEn` averages one pulse per 16·D/M cycles, and `pllEnable` is high.
- R3: `cpuClkEn` pulses on every N-th `periClkEn` pulse.
- R4: A wait request sets `inWait` and suppresses `cpuClkEn` from the next cycle on. If low-power-on-wait is clear, `periClkEn` keeps its rate. A wake pulse clears `inWait` and the CPU stream resumes.
- R5: A wait request with low-power-on-wait set turns `pllEnable` off. It also moves the source to the slow clock (one pulse per 256 cycles), or to the auxiliary clock if wait-uses-auxiliary is set and the auxiliary clock is present. This fallback survives the wake pulse and ends only on a control-word write.
- R6: The auxiliary clock is never the source while `auxPresent` is low. A request written while it is absent has no effect and is not remembered. Losing presence drops the auxiliary selection.
- R7: `auxPresent` is updated at the end of each 256-cycle window. It is set if at least 4 rising auxiliary-clock edges were seen in that window and cleared otherwise.
- R8: `xtalEnable` goes low only while the auxiliary clock is the source and either crystal stop is set or a low-power wait fallback is active.
- R9: When interrupts are enabled, `clkIrqN` drops low for one cycle on a hardware-stop restart pulse. It does the same whenever `srcAux` or `srcSlow` changes value.
- R10: With the interrupt enable bit clear, `clkIrqN` stays high.
- R11: Setting slow select by a plain write selects the slow clock without any wait request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 15 | Control word value |
| wfiReq | input | 1 | Wait-for-interrupt request pulse |
| wakeIrq | input | 1 | Wake interrupt pulse, ends the wait |
| auxClkIn | input | 1 | Raw auxiliary clock level |
| hwStopRestart | input | 1 | Pulse marking restart after a hardware stop |
| cpuClkEn | output | 1 | CPU clock enable pulse |
| periClkEn | output | 1 | Peripheral clock enable pulse |
| pllEnable | output | 1 | PLL run control |
| xtalEnable | output | 1 | Crystal oscillator run control |
| auxPresent | output | 1 | Auxiliary clock detected |
| srcAux | output | 1 | Auxiliary clock is the source |
| srcSlow | output | 1 | Slow clock is the source |
| inWait | output | 1 | Processor is in the wait state |
| clkIrqN | output | 1 | Active-low clock interrupt pulse |

## Verification
Some properties are checked on every cycle by assertions:
- the auxiliary source is never chosen without a presence indication from the previous cycle;
- a wait request blanks the CPU stream on the next cycle;
- a low-power wait turns the PLL off;
- a low crystal enable always coincides with the auxiliary source;
- interrupt pulses follow a restart only when enabled, and never appear while masked.

Other behaviour needs the bench scenarios:
- pulse intervals for each multiplier, divider and prescaler setting;
- the persistence of the fallback after wake;
- the presence detector reacting to an auxiliary clock that starts and stops;
- the ignored auxiliary request.

// File: rtl/clk_lp_pkg.sv
package clk_lp_pkg;

  typedef enum logic [1:0] {
    SRC_XTAL2 = 2'd0,
    SRC_PLL   = 2'd1,
    SRC_SLOW  = 2'd2,
    SRC_AUX   = 2'd3
  } srcSel_t;

  // control word, bit 14 down to bit 0
  typedef struct packed {
    logic       irqEn;
    logic       waitAux;
    logic       lpWait;
    logic       xtalStop;
    logic       auxReq;
    logic       slowSel;
    logic       pllOn;
    logic [2:0] preField;
    logic [2:0] divField;
    logic [1:0] mulCode;
  } ctrlWord_t;

  // strobes from control to datapath
  typedef struct packed {
    srcSel_t    src;
    logic       pllRun;
    logic       xtalRun;
    logic       cpuHold;
    logic [3:0] mulVal;
    logic [3:0] divVal;
    logic [2:0] preN;
  } dpCtrl_t;

  function automatic logic [3:0] mulDecode(input logic [1:0] code);
    case (code)
      2'b00:   mulDecode = 4'd10;
      2'b01:   mulDecode = 4'd6;
      2'b10:   mulDecode = 4'd14;
      default: mulDecode = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/clk_lp_datapath.sv
module clk_lp_datapath
  import clk_lp_pkg::*;
#(
  parameter int REF_RATIO   = 16,
  parameter int SLOW_DIV    = 16,
  parameter int PRES_WINDOW = 256,
  parameter int PRES_MIN    = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t dpCtrl,
  input  logic    auxClkIn,
  output logic    auxPresent,
  output logic    periClkEn,
  output logic    cpuClkEn
);

  localparam int XC_W  = (REF_RATIO > 1) ? $clog2(REF_RATIO) : 1;
  localparam int SD_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int PW_W  = $clog2(PRES_WINDOW);
  localparam int EC_W  = $clog2(PRES_MIN + 1);
  localparam int ACC_W = $clog2(REF_RATIO * 8 + 16) + 1;

  // half-rate crystal tick
  logic [XC_W-1:0] xtalCnt;
  logic            xtal2Tick;
  assign xtal2Tick = dpCtrl.xtalRun && (xtalCnt == XC_W'(REF_RATIO - 1));

  always_ff @(posedge clk) begin
    if (!rstN) xtalCnt <= '0;
    else if (dpCtrl.xtalRun)
      xtalCnt <= (xtalCnt == XC_W'(REF_RATIO - 1)) ? '0 : xtalCnt + 1'b1;
  end

  // slow clock: half-rate crystal divided by SLOW_DIV
  logic [SD_W-1:0] slowSub;
  logic            slowTick;
  assign slowTick = xtal2Tick && (slowSub == SD_W'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) slowSub <= '0;
    else if (xtal2Tick)
      slowSub <= (slowSub == SD_W'(SLOW_DIV - 1)) ? '0 : slowSub + 1'b1;
  end

  // PLL rate as fractional accumulator: M/(REF_RATIO*D) pulses per cycle
  logic [ACC_W-1:0] pllAcc, pllSum, pllThr;
  logic             pllTickQ;
  assign pllThr = ACC_W'(REF_RATIO) * ACC_W'(dpCtrl.divVal);
  assign pllSum = pllAcc + ACC_W'(dpCtrl.mulVal);

  always_ff @(posedge clk) begin
    if (!rstN || !dpCtrl.pllRun) begin
      pllAcc   <= '0;
      pllTickQ <= 1'b0;
    end else if (pllSum >= pllThr) begin
      pllAcc   <= pllSum - pllThr;
      pllTickQ <= 1'b1;
    end else begin
      pllAcc   <= pllSum;
      pllTickQ <= 1'b0;
    end
  end

  // auxiliary clock synchroniser and edge detector
  logic auxS1, auxS2, auxS3, auxTick;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxS1 <= 1'b0;
      auxS2 <= 1'b0;
      auxS3 <= 1'b0;
    end else begin
      auxS1 <= auxClkIn;
      auxS2 <= auxS1;
      auxS3 <= auxS2;
    end
  end
  assign auxTick = auxS2 && !auxS3;

  // presence window
  logic [PW_W-1:0] winCnt;
  logic [EC_W-1:0] edgeCnt, edgeNext;
  logic            auxPresentQ;
  assign edgeNext = (edgeCnt == EC_W'(PRES_MIN)) ? edgeCnt : edgeCnt + EC_W'(auxTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt      <= '0;
      edgeCnt     <= '0;
      auxPresentQ <= 1'b0;
    end else if (winCnt == PW_W'(PRES_WINDOW - 1)) begin
      winCnt      <= '0;
      edgeCnt     <= '0;
      auxPresentQ <= (edgeNext == EC_W'(PRES_MIN));
    end else begin
      winCnt  <= winCnt + 1'b1;
      edgeCnt <= edgeNext;
    end
  end
  assign auxPresent = auxPresentQ;

  // source multiplexer
  logic periTick;
  always_comb begin
    case (dpCtrl.src)
      SRC_PLL:  periTick = pllTickQ;
      SRC_SLOW: periTick = slowTick;
      SRC_AUX:  periTick = auxTick;
      default:  periTick = xtal2Tick;
    endcase
  end
  assign periClkEn = periTick;

  // CPU prescaler
  logic [2:0] preCnt;
  logic       cpuTick;
  assign cpuTick = periTick && (preCnt >= dpCtrl.preN);

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (periTick) preCnt <= cpuTick ? 3'd0 : preCnt + 3'd1;
  end
  assign cpuClkEn = cpuTick && !dpCtrl.cpuHold;

  // R2
  pll_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.pllRun |=> !pllTickQ);

endmodule

// File: rtl/clk_lp_control.sv
module clk_lp_control
  import clk_lp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [14:0] regWrData,
  input  logic        wfiReq,
  input  logic        wakeIrq,
  input  logic        hwStopRestart,
  input  logic        auxPresent,
  output dpCtrl_t     dpCtrl,
  output logic        pllEnable,
  output logic        xtalEnable,
  output logic        srcAux,
  output logic        srcSlow,
  output logic        inWait,
  output logic        clkIrqN
);

  ctrlWord_t ctrlQ, wrWord;
  logic      inWaitQ, fallbackQ, clkIrqNQ;
  srcSel_t   srcQ, srcNext;
  logic      irqEvt;

  assign wrWord = ctrlWord_t'(regWrData);

  // control word; auxiliary request only kept while the clock is present
  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (regWrEn) begin
      ctrlQ        <= wrWord;
      ctrlQ.auxReq <= wrWord.auxReq && auxPresent;
    end else if (!auxPresent) ctrlQ.auxReq <= 1'b0;
  end

  // wait state and low-power fallback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inWaitQ   <= 1'b0;
      fallbackQ <= 1'b0;
    end else begin
      if (wakeIrq)     inWaitQ <= 1'b0;
      else if (wfiReq) inWaitQ <= 1'b1;
      if (wfiReq && ctrlQ.lpWait) fallbackQ <= 1'b1;
      else if (regWrEn)           fallbackQ <= 1'b0;
    end
  end

  always_comb begin
    if (fallbackQ)                        srcNext = (ctrlQ.waitAux && auxPresent) ? SRC_AUX : SRC_SLOW;
    else if (ctrlQ.auxReq && auxPresent)  srcNext = SRC_AUX;
    else if (ctrlQ.slowSel)               srcNext = SRC_SLOW;
    else if (ctrlQ.pllOn)                 srcNext = SRC_PLL;
    else                                  srcNext = SRC_XTAL2;
  end

  assign irqEvt = hwStopRestart
               || ((srcNext == SRC_AUX)  != (srcQ == SRC_AUX))
               || ((srcNext == SRC_SLOW) != (srcQ == SRC_SLOW));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= SRC_XTAL2;
      clkIrqNQ <= 1'b1;
    end else begin
      srcQ     <= srcNext;
      clkIrqNQ <= !(irqEvt && ctrlQ.irqEn);
    end
  end

  assign pllEnable  = ctrlQ.pllOn && !fallbackQ;
  assign xtalEnable = !((srcQ == SRC_AUX) && (ctrlQ.xtalStop || fallbackQ));
  assign srcAux     = (srcQ == SRC_AUX);
  assign srcSlow    = (srcQ == SRC_SLOW);
  assign inWait     = inWaitQ;
  assign clkIrqN    = clkIrqNQ;

  always_comb begin
    dpCtrl.src     = srcQ;
    dpCtrl.pllRun  = pllEnable;
    dpCtrl.xtalRun = xtalEnable;
    dpCtrl.cpuHold = inWaitQ;
    dpCtrl.mulVal  = mulDecode(ctrlQ.mulCode);
    dpCtrl.divVal  = {1'b0, ctrlQ.divField} + 4'd1;
    dpCtrl.preN    = ctrlQ.preField;
  end

  // R6
  aux_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcQ == SRC_AUX) |-> $past(auxPresent));

  // R5
  lp_pll_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wfiReq && ctrlQ.lpWait) |=> !pllEnable);

  // R9
  restart_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwStopRestart && ctrlQ.irqEn) |=> !clkIrqN);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.irqEn |=> clkIrqN);

endmodule

// File: rtl/clk_lp_ctrl.sv
module clk_lp_ctrl
  import clk_lp_pkg::*;
#(
  parameter int REF_RATIO   = 16,
  parameter int SLOW_DIV    = 16,
  parameter int PRES_WINDOW = 256,
  parameter int PRES_MIN    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [14:0] regWrData,
  input  logic        wfiReq,
  input  logic        wakeIrq,
  input  logic        auxClkIn,
  input  logic        hwStopRestart,
  output logic        cpuClkEn,
  output logic        periClkEn,
  output logic        pllEnable,
  output logic        xtalEnable,
  output logic        auxPresent,
  output logic        srcAux,
  output logic        srcSlow,
  output logic        inWait,
  output logic        clkIrqN
);

  dpCtrl_t dpCtrl;

  clk_lp_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .wfiReq       (wfiReq),
    .wakeIrq      (wakeIrq),
    .hwStopRestart(hwStopRestart),
    .auxPresent   (auxPresent),
    .dpCtrl       (dpCtrl),
    .pllEnable    (pllEnable),
    .xtalEnable   (xtalEnable),
    .srcAux       (srcAux),
    .srcSlow      (srcSlow),
    .inWait       (inWait),
    .clkIrqN      (clkIrqN)
  );

  clk_lp_datapath #(
    .REF_RATIO  (REF_RATIO),
    .SLOW_DIV   (SLOW_DIV),
    .PRES_WINDOW(PRES_WINDOW),
    .PRES_MIN   (PRES_MIN)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .auxClkIn  (auxClkIn),
    .auxPresent(auxPresent),
    .periClkEn (periClkEn),
    .cpuClkEn  (cpuClkEn)
  );

  // R4
  wait_gates_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wfiReq && !wakeIrq) |=> !cpuClkEn);

  // R8
  xtal_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xtalEnable |-> srcAux);

endmodule

// File: tb/clk_lp_ctrl_bench.sv
module clk_lp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [14:0] regWrData = '0;
  logic        wfiReq = 1'b0, wakeIrq = 1'b0, auxClkIn = 1'b0, hwStopRestart = 1'b0;
  logic        cpuClkEn, periClkEn, pllEnable, xtalEnable, auxPresent;
  logic        srcAux, srcSlow, inWait, clkIrqN;

  always #4 clk = ~clk;

  clk_lp_ctrl u_clk_lp_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .wfiReq(wfiReq), .wakeIrq(wakeIrq), .auxClkIn(auxClkIn),
    .hwStopRestart(hwStopRestart), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .pllEnable(pllEnable), .xtalEnable(xtalEnable), .auxPresent(auxPresent),
    .srcAux(srcAux), .srcSlow(srcSlow), .inWait(inWait), .clkIrqN(clkIrqN)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct { string tag; int periIv; int cpuIv; } rateItem_t;
  rateItem_t sbQ[$];
  int doneCnt = 0, pushCnt = 0;

  // auxiliary clock: half period 6 cycles, rising edge every 12
  bit auxOn = 0;
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!auxOn) begin auxClkIn = 1'b0; cnt = 0; end
      else begin
        cnt++;
        if (cnt == 6) begin auxClkIn = ~auxClkIn; cnt = 0; end
      end
    end
  end

  // falling-edge counter on the interrupt line
  int irqFalls = 0;
  logic prevIrq = 1'b1;
  always @(negedge clk) begin
    if (prevIrq && !clkIrqN) irqFalls++;
    prevIrq <= clkIrqN;
  end

  task automatic chkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measPulse(input bit useCpu, input int limit, output int iv);
    int n = 0;
    bit seen = 0;
    iv = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (seen) n++;
      if (useCpu ? cpuClkEn : periClkEn) begin
        if (seen) begin iv = n; return; end
        seen = 1; n = 0;
      end
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      rateItem_t it;
      int iv, cnt;
      @(negedge clk);
      if (sbQ.size() != 0) begin
        it = sbQ[0];
        measPulse(1'b0, 3 * it.periIv + 40, iv);
        measPulse(1'b0, 3 * it.periIv + 40, iv);
        chkVal(it.tag, "periClkEn interval", iv, it.periIv);
        if (it.cpuIv == 0) begin
          cnt = 0;
          for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (cpuClkEn) cnt++;
          end
          chkVal(it.tag, "cpuClkEn pulses while held", cnt, 0);
        end else begin
          measPulse(1'b1, 3 * it.cpuIv + 40, iv);
          measPulse(1'b1, 3 * it.cpuIv + 40, iv);
          chkVal(it.tag, "cpuClkEn interval", iv, it.cpuIv);
        end
        void'(sbQ.pop_front());
        doneCnt++;
      end
    end
  end

  task automatic expectRates(input string tag, input int p, input int c);
    rateItem_t it;
    it.tag = tag; it.periIv = p; it.cpuIv = c;
    sbQ.push_back(it);
    pushCnt++;
    while (doneCnt != pushCnt) @(negedge clk);
  endtask

  function automatic logic [14:0] mk(input logic [1:0] mul, input int divF, input int preF,
      input bit pll, input bit slow, input bit aux, input bit xs,
      input bit lpw, input bit wa, input bit ie);
    return {ie, wa, lpw, xs, aux, slow, pll, 3'(preF), 3'(divF), mul};
  endfunction

  task automatic wr(input logic [14:0] w);
    @(negedge clk); regWrEn = 1'b1; regWrData = w;
    @(negedge clk); regWrEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseWfi();
    @(negedge clk); wfiReq = 1'b1;
    @(negedge clk); wfiReq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeIrq = 1'b1;
    @(negedge clk); wakeIrq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseRestart();
    @(negedge clk); hwStopRestart = 1'b1;
    @(negedge clk); hwStopRestart = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkVal("R1", "pllEnable", pllEnable, 0);
    chkVal("R1", "xtalEnable", xtalEnable, 1);
    chkVal("R1", "clkIrqN", clkIrqN, 1);
    chkVal("R1", "srcAux", srcAux, 0);
    chkVal("R1", "srcSlow", srcSlow, 0);
    chkVal("R1", "inWait", inWait, 0);
    chkVal("R1", "auxPresent", auxPresent, 0);
    expectRates("R1", 16, 16);

    // R2 PLL x8 /2, R3 prescaler N=2
    wr(mk(2'b11, 1, 1, 1, 0, 0, 0, 0, 0, 0));
    chkVal("R2", "pllEnable", pllEnable, 1);
    expectRates("R2", 4, 8);
    wr(mk(2'b10, 6, 0, 1, 0, 0, 0, 0, 0, 0));
    expectRates("R2", 8, 8);
    wr(mk(2'b00, 4, 3, 1, 0, 0, 0, 0, 0, 0));
    expectRates("R3", 8, 32);

    // R4 plain wait
    pulseWfi();
    chkVal("R4", "inWait", inWait, 1);
    expectRates("R4", 8, 0);
    pulseWake();
    chkVal("R4", "inWait after wake", inWait, 0);
    expectRates("R4", 8, 32);

    // R5 low-power wait to slow clock, R9 interrupt
    wr(mk(2'b00, 4, 0, 1, 0, 0, 0, 1, 0, 1));
    base = irqFalls;
    pulseWfi();
    chkVal("R5", "srcSlow", srcSlow, 1);
    chkVal("R5", "pllEnable", pllEnable, 0);
    chkVal("R9", "irq on slow select", irqFalls, base + 1);
    expectRates("R5", 256, 0);
    pulseWake();
    chkVal("R5", "srcSlow kept after wake", srcSlow, 1);
    expectRates("R5", 256, 256);
    base = irqFalls;
    wr(mk(2'b00, 4, 0, 1, 0, 0, 0, 0, 0, 1));
    chkVal("R5", "srcSlow after rewrite", srcSlow, 0);
    chkVal("R9", "irq on slow deselect", irqFalls, base + 1);
    expectRates("R5", 8, 8);

    // R11 direct slow select, R10 masked
    base = irqFalls;
    wr(mk(2'b00, 4, 0, 1, 1, 0, 0, 0, 0, 0));
    chkVal("R11", "srcSlow", srcSlow, 1);
    chkVal("R11", "inWait", inWait, 0);
    chkVal("R10", "no irq when masked", irqFalls, base);
    expectRates("R11", 256, 256);
    wr(mk(2'b00, 4, 0, 1, 0, 0, 0, 0, 0, 0));
    chkVal("R10", "no irq when masked", irqFalls, base);

    // R6 request while absent
    base = irqFalls;
    wr(mk(2'b00, 4, 0, 1, 0, 1, 0, 0, 0, 1));
    chkVal("R6", "srcAux while absent", srcAux, 0);
    expectRates("R6", 8, 8);
    chkVal("R6", "no irq", irqFalls, base);

    // R7 presence
    auxOn = 1;
    repeat (600) @(negedge clk);
    chkVal("R7", "auxPresent", auxPresent, 1);
    chkVal("R6", "request not remembered", srcAux, 0);
    base = irqFalls;
    wr(mk(2'b00, 4, 0, 1, 0, 1, 0, 0, 0, 1));
    chkVal("R6", "srcAux when present", srcAux, 1);
    chkVal("R9", "irq on aux select", irqFalls, base + 1);
    chkVal("R8", "xtalEnable no stop", xtalEnable, 1);
    expectRates("R6", 12, 12);
    wr(mk(2'b00, 4, 0, 1, 0, 1, 1, 0, 0, 1));
    chkVal("R8", "xtalEnable with stop", xtalEnable, 0);

    // R7 loss of presence
    base = irqFalls;
    auxOn = 0;
    repeat (600) @(negedge clk);
    chkVal("R7", "auxPresent cleared", auxPresent, 0);
    chkVal("R6", "srcAux dropped", srcAux, 0);
    chkVal("R8", "xtalEnable restored", xtalEnable, 1);
    chkVal("R9", "irq on aux loss", irqFalls, base + 1);
    expectRates("R6", 8, 8);

    // R5 wait falling back to auxiliary clock
    auxOn = 1;
    repeat (600) @(negedge clk);
    wr(mk(2'b00, 4, 0, 1, 0, 0, 0, 1, 1, 1));
    pulseWfi();
    chkVal("R5", "srcAux in wait", srcAux, 1);
    chkVal("R8", "xtalEnable in aux wait", xtalEnable, 0);
    chkVal("R5", "pllEnable in aux wait", pllEnable, 0);
    expectRates("R5", 12, 0);
    pulseWake();

    // R9 / R10 restart pulse
    base = irqFalls;
    pulseRestart();
    chkVal("R9", "irq on restart", irqFalls, base + 1);
    wr(mk(2'b00, 4, 0, 1, 0, 0, 0, 0, 0, 0));
    base = irqFalls;
    pulseRestart();
    chkVal("R10", "restart masked", irqFalls, base);
    chkVal("R10", "clkIrqN high", clkIrqN, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule